// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block keeps a 32-bit floating-point status and control word. Each completed arithmetic operation reports its exceptions as a vector of flags, and the block folds them into the word in a single clock. The flags that record exceptions are sticky. A summary bit notes that some exception has happened, and an invalid-operation summary gathers the nine invalid sub-causes. An enabled-exception summary is recomputed against the five enable bits on every update, and this summary drives a one-cycle trap request. The block does not work out the exceptions itself; the arithmetic units do that.

When an operation carries the record flag, the block returns a copy of the incoming condition-register word. In that copy, bits 27..24 are replaced by the four most significant bits of the updated status word, and a write-enable pulse goes with it. Software loads the whole word through a direct write strobe. That strobe has priority over an update in the same cycle.

Top module: `fpx_status_rec`

## Requirements
- R1: After reset, status_o is 0, and trap_o and cr_we_o are 0.
- R2: An update (upd_i=1, wr_i=0) with any bit of flags_i set makes status bit 31 (summary) equal to 1 in the following cycle.
- R3: The primary flags map as follows on an update: flags_i bit 0 (overflow) to status bit 28, bit 1 (underflow) to bit 27, bit 2 (divide by zero) to bit 26, bit 3 (inexact) to bit 25, and bit 4 (invalid) to bit 29.
- R4: The invalid sub-cause flags map as follows on an update: flags_i bits 5..10 (signalling NaN, inf-inf, inf/inf, 0/0, inf*0, invalid compare) set status bits 24 down to 19, and flags_i bits 11..13 (software request, square root of negative, invalid integer convert) set status bits 10, 9 and 8.
- R5: After every update, status bit 29 (invalid summary) is 1 whenever any of the sub-cause bits 24..19 or 10..8 is 1. This includes sub-cause bits that were loaded earlier by a direct write.
- R6: Every update recomputes status bit 30 (enabled summary), clearing it first. It is 1 exactly when at least one of these pairs is both 1 in the updated word: 29 with enable 7, 28 with enable 6, 27 with enable 5, 26 with enable 4, 25 with enable 3.
- R7: trap_o is 1 for exactly the one cycle that follows an update whose recomputed bit 30 is 1. At all other times it is 0.
- R8: An update with rec_i=1 gives cr_we_o=1 in the next cycle. Along with it, cr_o equals cr_i from the update cycle with bits 27..24 replaced by updated status bits 31..28. An update without rec_i leaves cr_we_o at 0.
- R9: A direct write (wr_i=1) loads wr_data_i into the status word verbatim. It overrides an update in the same cycle, and that update then produces neither trap_o nor cr_we_o.
- R10: An update never clears sticky bits 31, 29..19 or 10..8. It leaves enables 7..3 and the other bits 18..11 and 2..0 unchanged, and an idle cycle leaves the whole word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Update strobe: fold flags_i into the status word |
| flags_i | input | 14 | Exception flags of the finished operation |
| rec_i | input | 1 | Record flag: copy the status nibble to the condition word |
| cr_i | input | 32 | Current condition-register word |
| wr_i | input | 1 | Direct write strobe |
| wr_data_i | input | 32 | Value for the direct write |
| status_o | output | 32 | Status and control word |
| trap_o | output | 1 | Trap request pulse |
| cr_we_o | output | 1 | Condition-register write enable pulse |
| cr_o | output | 32 | Condition-register word with the status nibble spliced in |

## Verification
The hardest states to reach are the ones where the summary bits disagree with the rest of the word, because updates alone never create them. An example is a set enabled-summary bit with no matching enable pair, or a sub-cause bit with the invalid summary clear. The stimulus builds these states through the direct write. It then issues updates with no flags, so only the recomputation acts: the enabled summary must fall, the invalid summary must rise, and a trap must appear from an enable that software set after the exception was already recorded. A write and an update in the same cycle, and reserved bits preloaded with ones, cover the priority and preservation rules.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int STAT_W   = 32;
  localparam int NUM_PRIM = 5;
  localparam int NUM_SUB  = 9;
  localparam int NUM_FLAG = NUM_PRIM + NUM_SUB;
  localparam int POS_W    = $clog2(STAT_W);

  typedef logic [POS_W-1:0]  bpos_t;
  typedef logic [STAT_W-1:0] stat_t;

  // flags_i layout: primaries in the low bits, sub-causes above
  typedef struct packed {
    logic [NUM_SUB-1:0]  sub;
    logic [NUM_PRIM-1:0] prim;
  } flags_t;

  localparam bpos_t B_FX  = bpos_t'(31);
  localparam bpos_t B_FEX = bpos_t'(30);
  localparam bpos_t B_VX  = bpos_t'(29);
  localparam bpos_t B_OX  = bpos_t'(28);

  // primary i: 0 ovf, 1 unf, 2 zdiv, 3 inexact, 4 invalid
  function automatic bpos_t prim_pos(int i);
    return (i == NUM_PRIM - 1) ? B_VX : bpos_t'(int'(B_OX) - i);
  endfunction

  function automatic bpos_t en_pos(int i);
    return (i == NUM_PRIM - 1) ? bpos_t'(7) : bpos_t'(6 - i);
  endfunction

  // sub-cause i: six in the upper group, three in the lower group
  function automatic bpos_t sub_pos(int i);
    return (i < 6) ? bpos_t'(24 - i) : bpos_t'(16 - i);
  endfunction

  function automatic stat_t calc_sub_mask();
    stat_t m = '0;
    for (int i = 0; i < NUM_SUB; i++) m[sub_pos(i)] = 1'b1;
    return m;
  endfunction

  function automatic stat_t calc_sticky_mask();
    stat_t m = calc_sub_mask();
    m[B_FX] = 1'b1;
    for (int i = 0; i < NUM_PRIM; i++) m[prim_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam stat_t SUB_MASK    = calc_sub_mask();
  localparam stat_t STICKY_MASK = calc_sticky_mask();
  localparam stat_t KEEP_MASK   = ~(STICKY_MASK | (stat_t'(1) << B_FEX));
endpackage

// File: rtl/fpx_flag_merge.sv
module fpx_flag_merge
  import fpx_pkg::*;
(
  input  stat_t  status_i,
  input  flags_t flags_i,
  output stat_t  status_o
);
  stat_t m;

  always_comb begin
    m = status_i;
    if (flags_i != '0) m[B_FX] = 1'b1;
    for (int i = 0; i < NUM_PRIM; i++)
      if (flags_i.prim[i]) m[prim_pos(i)] = 1'b1;
    for (int i = 0; i < NUM_SUB; i++)
      if (flags_i.sub[i]) m[sub_pos(i)] = 1'b1;
    // invalid summary covers old and new sub-causes
    if ((m & SUB_MASK) != '0) m[B_VX] = 1'b1;
    status_o = m;
  end
endmodule

// File: rtl/fpx_enable_eval.sv
module fpx_enable_eval #(
  parameter int NUM_PAIR = 5
) (
  input  logic [NUM_PAIR-1:0] exc_i,
  input  logic [NUM_PAIR-1:0] en_i,
  output logic                fex_o
);
  logic [NUM_PAIR-1:0] hit;

  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
    assign hit[g] = exc_i[g] & en_i[g];
  end

  assign fex_o = |hit;
endmodule

// File: rtl/fpx_cr_splice.sv
module fpx_cr_splice #(
  parameter int CR_W   = 32,
  parameter int CR_LSB = 24,
  parameter int NIB_W  = 4
) (
  input  logic [CR_W-1:0]  cr_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [CR_W-1:0]  cr_o
);
  localparam logic [CR_W-1:0] FIELD = {{(CR_W-NIB_W){1'b0}}, {NIB_W{1'b1}}} << CR_LSB;

  assign cr_o = (cr_i & ~FIELD) | ({{(CR_W-NIB_W){1'b0}}, nib_i} << CR_LSB);
endmodule

// File: rtl/fpx_status_rec.sv
module fpx_status_rec
  import fpx_pkg::*;
#(
  parameter int CR_W   = 32,
  parameter int CR_LSB = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic [NUM_FLAG-1:0] flags_i,
  input  logic                rec_i,
  input  logic [CR_W-1:0]     cr_i,
  input  logic                wr_i,
  input  logic [STAT_W-1:0]   wr_data_i,
  output logic [STAT_W-1:0]   status_o,
  output logic                trap_o,
  output logic                cr_we_o,
  output logic [CR_W-1:0]     cr_o
);
  localparam int NIB_W = 4;

  stat_t                status_q, merged, upd_val;
  logic [NUM_PRIM-1:0]  exc, en;
  logic                 fex, upd_go;
  logic [CR_W-1:0]      cr_new, cr_q;
  logic                 trap_q, cr_we_q;

  fpx_flag_merge i_merge (
    .status_i (status_q),
    .flags_i  (flags_t'(flags_i)),
    .status_o (merged)
  );

  always_comb begin
    for (int i = 0; i < NUM_PRIM; i++) begin
      exc[i] = merged[prim_pos(i)];
      en[i]  = merged[en_pos(i)];
    end
  end

  fpx_enable_eval #(.NUM_PAIR(NUM_PRIM)) i_enable (
    .exc_i (exc),
    .en_i  (en),
    .fex_o (fex)
  );

  always_comb begin
    upd_val        = merged;
    upd_val[B_FEX] = fex;
  end

  fpx_cr_splice #(.CR_W(CR_W), .CR_LSB(CR_LSB), .NIB_W(NIB_W)) i_splice (
    .cr_i  (cr_i),
    .nib_i (upd_val[STAT_W-1 -: NIB_W]),
    .cr_o  (cr_new)
  );

  // software write wins over a same-cycle update
  assign upd_go = upd_i & ~wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      trap_q   <= 1'b0;
      cr_we_q  <= 1'b0;
      cr_q     <= '0;
    end else begin
      if (wr_i)        status_q <= wr_data_i;
      else if (upd_i)  status_q <= upd_val;
      trap_q  <= upd_go & fex;
      cr_we_q <= upd_go & rec_i;
      if (upd_go && rec_i) cr_q <= cr_new;
    end
  end

  assign status_o = status_q;
  assign trap_o   = trap_q;
  assign cr_we_o  = cr_we_q;
  assign cr_o     = cr_q;

  a_r2_fx_on_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i && flags_i != '0) |=> status_q[B_FX]);

  a_r5_vx_covers_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i) |=> ((status_q & SUB_MASK) == '0 || status_q[B_VX]));

  a_r6_fex_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i) |=> status_q[B_FEX] ==
      ((status_q[29] & status_q[7]) | (status_q[28] & status_q[6]) |
       (status_q[27] & status_q[5]) | (status_q[26] & status_q[4]) |
       (status_q[25] & status_q[3])));

  a_r7_trap_needs_fex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> status_q[B_FEX]);

  a_r8_cr_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> cr_o[CR_LSB +: NIB_W] == status_q[STAT_W-1 -: NIB_W]);

  a_r9_write_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (status_q == $past(wr_data_i) && !trap_o && !cr_we_o));

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((($past(status_q) & ~status_q) & STICKY_MASK) == '0));

  a_r10_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((($past(status_q) ^ status_q) & KEEP_MASK) == '0));
endmodule

// File: tb/test_fpx_status_rec.sv
module test_fpx_status_rec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0, rec = 1'b0, wr = 1'b0;
  logic [13:0] flags = '0;
  logic [31:0] cr_in = '0, wr_data = '0;
  logic [31:0] status, cr_out;
  logic        trap, cr_we;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] st;
    bit          trap;
    bit          crwe;
    logic [31:0] cr;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [31:0] m_st = '0;

  always #5 clk = ~clk;

  fpx_status_rec i_fpx_status_rec (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .flags_i(flags), .rec_i(rec),
    .cr_i(cr_in), .wr_i(wr), .wr_data_i(wr_data), .status_o(status),
    .trap_o(trap), .cr_we_o(cr_we), .cr_o(cr_out)
  );

  function automatic logic [31:0] upd_model(logic [31:0] s, logic [13:0] f);
    int subp[9] = '{24, 23, 22, 21, 20, 19, 10, 9, 8};
    logic [31:0] n = s;
    if (f != '0) n[31] = 1'b1;
    if (f[0]) n[28] = 1'b1;
    if (f[1]) n[27] = 1'b1;
    if (f[2]) n[26] = 1'b1;
    if (f[3]) n[25] = 1'b1;
    if (f[4]) n[29] = 1'b1;
    for (int i = 0; i < 9; i++) if (f[5+i]) n[subp[i]] = 1'b1;
    for (int i = 0; i < 9; i++) if (n[subp[i]]) n[29] = 1'b1;
    n[30] = (n[29] & n[7]) | (n[28] & n[6]) | (n[27] & n[5]) |
            (n[26] & n[4]) | (n[25] & n[3]);
    return n;
  endfunction

  task automatic step(bit u, bit w, logic [13:0] f, bit rc, logic [31:0] c,
                      logic [31:0] wd, string tag);
    exp_t e;
    @(negedge clk);
    upd = u; wr = w; flags = f; rec = rc; cr_in = c; wr_data = wd;
    e.tag = tag; e.trap = 0; e.crwe = 0; e.cr = '0;
    if (w) m_st = wd;
    else if (u) begin
      m_st = upd_model(m_st, f);
      e.trap = m_st[30];
      e.crwe = rc;
      e.cr = {c[31:28], m_st[31:28], c[23:0]};
    end
    e.st = m_st;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(0, 0, '0, 0, '0, '0, tag);
  endtask

  task automatic wrw(logic [31:0] v, string tag);
    step(0, 1, '0, 0, '0, v, tag);
  endtask

  task automatic upd_f(logic [13:0] f, string tag);
    step(1, 0, f, 0, '0, '0, tag);
  endtask

  // monitor: compares each cycle against the scoreboard
  initial begin
    exp_t e;
    bit ok;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        ok = (status === e.st) && (trap === e.trap) && (cr_we === e.crwe) &&
             (!e.crwe || cr_out === e.cr);
        n_chk++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: status=%h trap=%b cr_we=%b cr=%h expected status=%h trap=%b cr_we=%b cr=%h",
                   e.tag, status, trap, cr_we, cr_out, e.st, e.trap, e.crwe, e.cr);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (status !== 32'h0 || trap !== 1'b0 || cr_we !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: status=%h trap=%b cr_we=%b expected 0 0 0", status, trap, cr_we);
    end
    rst_n = 1'b1;
    idle("R10 idle after reset");

    // primary flags one by one, no enables
    upd_f(14'h0001, "R2 R3 overflow");
    upd_f(14'h0002, "R3 underflow");
    upd_f(14'h0004, "R3 divide by zero");
    upd_f(14'h0008, "R3 inexact");
    upd_f(14'h0010, "R3 invalid");
    upd_f(14'h0000, "R10 sticky after empty update");

    // sub-causes one at a time from a clear word
    for (int i = 0; i < 9; i++) begin
      wrw(32'h0, "R9 clear");
      upd_f(14'(1 << (5 + i)), $sformatf("R4 R5 sub-cause %0d", i));
    end

    // sub-cause preloaded without summary: update with no flags
    wrw(32'h0008_0000, "R9 preload compare cause");
    upd_f(14'h0000, "R5 summary raised from preload");
    wrw(32'h0000_0200, "R9 preload sqrt cause");
    upd_f(14'h0000, "R5 summary raised from low group");

    // stale enabled summary must drop
    wrw(32'h4000_0000, "R9 preload stale summary");
    upd_f(14'h0000, "R6 stale summary cleared");

    // enable set after exception recorded
    wrw(32'h1000_0040, "R9 overflow with enable");
    upd_f(14'h0000, "R6 R7 late enable traps");
    idle("R7 trap is one pulse");

    // each enable pair fires
    for (int i = 0; i < 5; i++) begin
      wrw(32'(1 << ((i == 4) ? 7 : 6 - i)), $sformatf("R9 enable %0d", i));
      upd_f(14'(1 << i), $sformatf("R6 R7 pair %0d", i));
    end
    upd_f(14'h0100, "R6 enabled summary stays with pair");

    // record flag
    wrw(32'h0000_0000, "R9 clear");
    step(1, 0, 14'h0001, 1, 32'hFFFF_FFFF, '0, "R8 record ones");
    step(1, 0, 14'h0008, 1, 32'h0000_0000, '0, "R8 record zeros");
    step(1, 0, 14'h0000, 0, 32'hFFFF_FFFF, '0, "R8 no record");

    // write and update together
    step(1, 1, 14'h3FFF, 1, 32'hFFFF_FFFF, 32'h0000_00F8, "R9 write beats update");
    idle("R9 no late effect");

    // reserved and enable bits preserved across updates
    wrw(32'h0007_F807, "R9 reserved ones");
    upd_f(14'h3FFF, "R10 reserved kept all flags");
    upd_f(14'h0000, "R10 sticky all set");
    idle("R10 idle");

    idle("final");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule